// File: doc/BRIEF.md
# Immediate Operand Extension Prefix Unit

This unit sits in the decode stage of a small 32-bit processor. The normal instruction format carries only a 9-bit immediate in its source field and in its destination field. Two prefix instructions let software build full 32-bit immediates. One prefix is for the source and one is for the destination. Each prefix carries a 23-bit payload, and the unit parks that payload in a pending slot for its field.

A later instruction that uses an immediate in the matching field takes the payload as bits 31:9 of its immediate. Its own 9-bit field supplies bits 8:0. Doing so empties the slot. Instructions that do not use an immediate in that field leave the slot alone, however many of them come first. The two slots are tracked separately, so both can be armed at once.

The decoder supplies per-field immediate flags, and the condition logic supplies a condition-pass bit. The unit returns both immediates and a marker saying that the word was a prefix, which performs no register write. All outputs are registered one cycle behind the accepted word.

Top module: `imm_prefix_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and empties both pending slots. After reset, the first immediate instruction receives a zero-extended immediate.
- R2: A valid word whose bits 27:23 equal 11110 is a source prefix, and 11111 is a destination prefix. One cycle later it yields `out_valid`=1, `prefix_nop`=1 and both immediates zero.
- R3: With no pending extension, `src_imm` is word bits 8:0 zero-extended and `dst_imm` is word bits 17:9 zero-extended, so the range is 0 to 511.
- R4: A non-prefix word with condition pass, its field's immediate flag set and that field's slot armed is a consumer. It yields the prefix's bits 22:0 in bits 31:9 of the immediate and its own 9-bit field in bits 8:0.
- R5: A non-prefix word does not disturb a slot when its immediate flag for that field is clear, and any number of such words may pass.
- R6: Consuming a slot empties it in the same cycle. The next immediate in that field is zero-extended again.
- R7: The source and destination slots are independent. One word with both flags set consumes both slots. A word with one flag set consumes only that slot.
- R8: A prefix of the same kind that arrives while its slot is armed replaces the payload, and the slot stays armed.
- R9: A word whose condition input is false changes no pending state. This holds for a prefix, which is discarded but still marked as a no-op, and for a would-be consumer, whose output is the zero-extended field.
- R10: A cycle with `in_valid` low gives `out_valid`=0 in the next cycle and leaves both slots unchanged.
- R11: A non-prefix word gives `out_valid`=1 and `prefix_nop`=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word accepted this cycle |
| in_word | input | 32 | Fetched instruction word |
| cond_pass | input | 1 | Condition field of this word evaluated true |
| src_is_imm | input | 1 | Decoder: source field is an immediate |
| dst_is_imm | input | 1 | Decoder: destination field is an immediate |
| out_valid | output | 1 | Registered outputs belong to an accepted word |
| src_imm | output | 32 | Source immediate, extended or zero-extended |
| dst_imm | output | 32 | Destination immediate, extended or zero-extended |
| prefix_nop | output | 1 | Accepted word was a prefix and writes nothing |

## Verification
The hardest case to reach is an armed slot that must survive a long mixed run. That run includes register-source words, words with an immediate only in the other field, words with a false condition, idle cycles, a second prefix that overwrites and a discarded prefix, all before the consumer arrives. Directed sequences build each of these chains deliberately. A long stretch of random words then uses a small opcode alphabet with a high share of prefixes, so overlapping arm and consume patterns of both kinds occur often. A behavioural model checks every cycle of that stretch.

// File: rtl/imm_pfx_pkg.sv
package imm_pfx_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SRC  = 2'd1,
    PK_DST  = 2'd2
  } pfx_kind_t;

  localparam int SLOT_SRC = 0;
  localparam int SLOT_DST = 1;
  localparam int SLOTS    = 2;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import imm_pfx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int COND_W = 4,
  parameter int OPC_W  = 5,
  parameter int IMM_W  = 9,
  parameter logic [OPC_W-1:0] SRC_OPC = 5'b11110,
  parameter logic [OPC_W-1:0] DST_OPC = 5'b11111
) (
  input  logic [WORD_W-1:0]          word,
  output pfx_kind_t                  kind,
  output logic [WORD_W-IMM_W-1:0]    payload,
  output logic [IMM_W-1:0]           s_field,
  output logic [IMM_W-1:0]           d_field
);
  localparam int PAY_W  = WORD_W - IMM_W;
  localparam int OPC_HI = WORD_W - COND_W - 1;
  localparam int OPC_LO = OPC_HI - OPC_W + 1;

  logic [OPC_W-1:0] opc;

  assign opc     = word[OPC_HI:OPC_LO];
  assign payload = word[PAY_W-1:0];
  assign s_field = word[IMM_W-1:0];
  assign d_field = word[2*IMM_W-1:IMM_W];

  always_comb begin
    if (opc == SRC_OPC)      kind = PK_SRC;
    else if (opc == DST_OPC) kind = PK_DST;
    else                     kind = PK_NONE;
  end
endmodule

// File: rtl/ext_slot.sv
module ext_slot #(
  parameter int PAY_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [PAY_W-1:0] arm_payload,
  input  logic             consume,
  output logic             pend,
  output logic [PAY_W-1:0] payload
);
  // arm and consume come from disjoint word classes; arm wins regardless
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (arm) begin
      pend <= 1'b1;
    end else if (consume) begin
      pend <= 1'b0;
    end
  end

  // payload needs no reset: it is only read while pend is set
  always_ff @(posedge clk) begin
    if (arm) payload <= arm_payload;
  end
endmodule

// File: rtl/imm_out_reg.sv
module imm_out_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_d,
  input  logic              nop_d,
  input  logic [WORD_W-1:0] s_d,
  input  logic [WORD_W-1:0] d_d,
  output logic              vld_q,
  output logic              nop_q,
  output logic [WORD_W-1:0] s_q,
  output logic [WORD_W-1:0] d_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      nop_q <= 1'b0;
      s_q   <= '0;
      d_q   <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) begin
        nop_q <= nop_d;
        s_q   <= s_d;
        d_q   <= d_d;
      end
    end
  end
endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit
  import imm_pfx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int COND_W = 4,
  parameter int OPC_W  = 5,
  parameter int IMM_W  = 9,
  parameter logic [OPC_W-1:0] SRC_OPC = 5'b11110,
  parameter logic [OPC_W-1:0] DST_OPC = 5'b11111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              cond_pass,
  input  logic              src_is_imm,
  input  logic              dst_is_imm,
  output logic              out_valid,
  output logic [WORD_W-1:0] src_imm,
  output logic [WORD_W-1:0] dst_imm,
  output logic              prefix_nop
);
  localparam int PAY_W = WORD_W - IMM_W;

  pfx_kind_t        kind;
  logic [PAY_W-1:0] word_pay;
  logic [IMM_W-1:0] s_field, d_field;

  logic [IMM_W-1:0]  field   [SLOTS];
  logic              use_imm [SLOTS];
  pfx_kind_t         my_kind [SLOTS];
  logic              pend    [SLOTS];
  logic [PAY_W-1:0]  pay     [SLOTS];
  logic [WORD_W-1:0] imm_d   [SLOTS];

  logic is_prefix, take;
  logic s_pend, d_pend;

  pfx_decode #(
    .WORD_W(WORD_W), .COND_W(COND_W), .OPC_W(OPC_W), .IMM_W(IMM_W),
    .SRC_OPC(SRC_OPC), .DST_OPC(DST_OPC)
  ) u_dec (
    .word(in_word), .kind(kind), .payload(word_pay),
    .s_field(s_field), .d_field(d_field)
  );

  assign is_prefix = (kind != PK_NONE);
  assign take      = in_valid && cond_pass;

  assign field[SLOT_SRC]   = s_field;
  assign field[SLOT_DST]   = d_field;
  assign use_imm[SLOT_SRC] = src_is_imm;
  assign use_imm[SLOT_DST] = dst_is_imm;
  assign my_kind[SLOT_SRC] = PK_SRC;
  assign my_kind[SLOT_DST] = PK_DST;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic arm_g, use_g;

    assign arm_g = take && (kind == my_kind[g]);
    assign use_g = take && !is_prefix && use_imm[g] && pend[g];

    ext_slot #(.PAY_W(PAY_W)) u_slot (
      .clk(clk), .rst(rst),
      .arm(arm_g), .arm_payload(word_pay),
      .consume(use_g),
      .pend(pend[g]), .payload(pay[g])
    );

    always_comb begin
      if (is_prefix)  imm_d[g] = '0;
      else if (use_g) imm_d[g] = {pay[g], field[g]};
      else            imm_d[g] = {{PAY_W{1'b0}}, field[g]};
    end
  end

  assign s_pend = pend[SLOT_SRC];
  assign d_pend = pend[SLOT_DST];

  imm_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst),
    .vld_d(in_valid), .nop_d(is_prefix),
    .s_d(imm_d[SLOT_SRC]), .d_d(imm_d[SLOT_DST]),
    .vld_q(out_valid), .nop_q(prefix_nop),
    .s_q(src_imm), .d_q(dst_imm)
  );
endmodule

// File: rtl/imm_prefix_unit_chk.sv
module imm_prefix_unit_chk #(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              cond_pass,
  input logic              src_is_imm,
  input logic              out_valid,
  input logic [WORD_W-1:0] src_imm,
  input logic [WORD_W-1:0] dst_imm,
  input logic              prefix_nop,
  input logic              s_pend,
  input logic              d_pend
);
  logic pfx_word;
  assign pfx_word = (in_word[27:24] == 4'b1111);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !out_valid && !s_pend && !d_pend); // R1

  AST_PREFIX_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && prefix_nop |-> (src_imm == '0) && (dst_imm == '0)); // R2

  AST_NO_EXT_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_valid && !s_pend |=> (src_imm[WORD_W-1:IMM_W] == '0)); // R3

  AST_LOW_FIELD: assert property (@(posedge clk) disable iff (rst)
    in_valid && !pfx_word |=> (src_imm[IMM_W-1:0] == $past(in_word[IMM_W-1:0]))); // R4

  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    in_valid && cond_pass && !pfx_word && src_is_imm |=> !s_pend); // R6

  AST_COND_FALSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    in_valid && !cond_pass |=> $stable(s_pend) && $stable(d_pend)); // R9

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(s_pend) && $stable(d_pend)); // R10

  AST_PLAIN_NOT_NOP: assert property (@(posedge clk) disable iff (rst)
    in_valid && !pfx_word |=> out_valid && !prefix_nop); // R11
endmodule

bind imm_prefix_unit imm_prefix_unit_chk #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .cond_pass(cond_pass), .src_is_imm(src_is_imm),
  .out_valid(out_valid), .src_imm(src_imm), .dst_imm(dst_imm),
  .prefix_nop(prefix_nop), .s_pend(s_pend), .d_pend(d_pend)
);

// File: tb/imm_prefix_unit_test.sv
module imm_prefix_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        cond_pass = 1'b1;
  logic        src_is_imm = 1'b0;
  logic        dst_is_imm = 1'b0;
  logic        out_valid, prefix_nop;
  logic [31:0] src_imm, dst_imm;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string req = "R1";

  imm_prefix_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .cond_pass(cond_pass), .src_is_imm(src_is_imm), .dst_is_imm(dst_is_imm),
    .out_valid(out_valid), .src_imm(src_imm), .dst_imm(dst_imm),
    .prefix_nop(prefix_nop)
  );

  always #10 clk = ~clk;  // 50 MHz

  // behavioural reference model
  bit          m_vld, m_nop, m_sp, m_dp;
  logic [31:0] m_s, m_d;
  logic [22:0] m_spay, m_dpay;
  bit          chk_en = 0;

  always @(posedge clk) begin
    int op;
    bit cs, cd;
    if (rst) begin
      m_vld = 0; m_sp = 0; m_dp = 0;
    end else if (in_valid) begin
      op = in_word[27:23];
      m_vld = 1;
      if (op == 30 || op == 31) begin
        m_nop = 1; m_s = 0; m_d = 0;
        if (cond_pass) begin
          if (op == 30) begin m_sp = 1; m_spay = in_word[22:0]; end
          else          begin m_dp = 1; m_dpay = in_word[22:0]; end
        end
      end else begin
        m_nop = 0;
        cs = cond_pass && src_is_imm && m_sp;
        cd = cond_pass && dst_is_imm && m_dp;
        m_s = cs ? {m_spay, in_word[8:0]}  : {23'd0, in_word[8:0]};
        m_d = cd ? {m_dpay, in_word[17:9]} : {23'd0, in_word[17:9]};
        if (cs) m_sp = 0;
        if (cd) m_dp = 0;
      end
    end else begin
      m_vld = 0;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (chk_en && !finished) begin
      check("out_valid", {31'd0, out_valid}, {31'd0, m_vld});
      if (m_vld) begin
        check("prefix_nop", {31'd0, prefix_nop}, {31'd0, m_nop});
        check("src_imm", src_imm, m_s);
        check("dst_imm", dst_imm, m_d);
      end
    end
  end

  function automatic logic [31:0] pfx(bit dst, logic [22:0] p);
    return {4'hF, dst ? 5'b11111 : 5'b11110, p};
  endfunction

  function automatic logic [31:0] ins(logic [8:0] d, logic [8:0] s);
    return {4'hF, 5'b00101, 5'd0, d, s};
  endfunction

  task automatic put(logic [31:0] w, bit c, bit si, bit di);
    @(negedge clk);
    in_valid = 1; in_word = w; cond_pass = c; src_is_imm = si; dst_is_imm = di;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_word = 32'hDEAD_BEEF;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then zero-extended immediate
    repeat (3) @(negedge clk);
    chk_en = 1;
    @(negedge clk); rst = 0;
    req = "R1"; idle(1); put(ins(9'h1AB, 9'h1FF), 1, 1, 1);
    // R3: plain immediates in both fields
    req = "R3"; put(ins(9'h155, 9'h0AA), 1, 1, 1); put(ins(9'h000, 9'h1FF), 1, 1, 0);
    // R2 R4 R11: source prefix then consumer
    req = "R4"; put(pfx(0, 23'h5A5A5A), 1, 0, 0); put(ins(9'h011, 9'h123), 1, 1, 0);
    // R6: emptied after use
    req = "R6"; put(ins(9'h011, 9'h123), 1, 1, 0);
    // R5: long non-consuming run, including dst-only immediate and false condition
    req = "R5"; put(pfx(0, 23'h7FFFFF), 1, 0, 0);
    for (int i = 0; i < 20; i++) put(ins(9'(i), 9'(3*i)), 1, 0, 0);
    put(ins(9'h0F0, 9'h00F), 1, 0, 1);
    req = "R9"; put(ins(9'h0F0, 9'h00F), 0, 1, 1);
    req = "R10"; idle(4);
    req = "R5"; put(ins(9'h001, 9'h002), 1, 1, 0);
    // R7: both armed, one word consumes both; then one-sided use
    req = "R7"; put(pfx(1, 23'h123456), 1, 0, 0); put(pfx(0, 23'h654321), 1, 0, 0);
    put(ins(9'h1C0, 9'h03F), 1, 1, 1);
    put(pfx(1, 23'h0ABCDE), 1, 0, 0); put(pfx(0, 23'h00FEED), 1, 0, 0);
    put(ins(9'h1C0, 9'h03F), 1, 0, 1); put(ins(9'h1C0, 9'h03F), 1, 1, 1);
    // R8: overwrite
    req = "R8"; put(pfx(0, 23'h111111), 1, 0, 0); put(pfx(0, 23'h222222), 1, 0, 0);
    put(ins(9'h000, 9'h155), 1, 1, 0);
    // R9: false-condition prefix discarded, with and without armed slot
    req = "R9"; put(pfx(1, 23'h333333), 0, 0, 0); put(ins(9'h0AA, 9'h000), 1, 0, 1);
    put(pfx(1, 23'h444444), 1, 0, 0); put(pfx(1, 23'h555555), 0, 0, 0);
    put(ins(9'h0AA, 9'h000), 1, 0, 1);
    // R2: random mix, prefixes frequent
    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      case ($urandom_range(0, 3))
        0: w[27:23] = 5'b11110;
        1: w[27:23] = 5'b11111;
        default: w[27:23] = 5'(w[27:23] & 5'b01111);
      endcase
      if ($urandom_range(0, 7) == 0) idle(1);
      else put(w, $urandom_range(0, 5) != 0, 1'($urandom), 1'($urandom));
    end
    idle(2);
    // R1: reset mid-stream empties slots
    req = "R1"; put(pfx(0, 23'h0F0F0F), 1, 0, 0);
    @(negedge clk); rst = 1; in_valid = 0;
    @(negedge clk); rst = 0;
    put(ins(9'h000, 9'h077), 1, 1, 0);
    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule